// File: doc/BRIEF.md
# Dual-Channel Cascadable LCD Segment and Back-Plate Driver

This block is the digital front end of a 40-output LCD driver. It has two channels of 20 outputs. Each channel holds a serial shift register, a parallel latch and a per-output level selector. Serial data is clocked in on a shift strobe. The shift direction of each channel is chosen by its own direction input. Each channel has two serial end ports. The port at the upstream end of the shift takes data in, and the port at the downstream end passes the departing bit on, so several blocks can be chained into one long display row.

A latch strobe copies every shift register into its latch in one step. Between latch strobes the outputs stay frozen while the next line is shifted in. Each output turns its latched bit and the alternation input into a 2-bit code, and that code picks one of four analog drive levels outside the block. Channel 1 always drives segments. A mode input makes channel 2 a back-plate (scan) driver instead. In that mode channel 2 uses the opposite level assignment, and a single active bit walked along its register selects one scan row per line. The analog switches and the bias supply lie outside the block.

Top module: `lcd_dual_drv`

## Requirements
- R1: While rst_ni is low, every shift register bit and latch bit is cleared. After reset with alt_i=0 every output code is 2'd2, and with alt_i=1 every output code is 2'd1.
- R2: On a clock edge with shift_i=1, a channel whose dir_i bit is 1 moves its bits from index k to k+1 and loads left_in_i into index 0. A channel whose dir_i bit is 0 moves its bits from index k to k-1 and loads right_in_i into index CH_BITS-1. With shift_i=0 the register holds its value.
- R3: With dir_i[c]=1, right_oe_o[c]=1, left_oe_o[c]=0, right_o[c] shows register bit CH_BITS-1 and left_o[c]=0. With dir_i[c]=0 the roles swap, and left_o[c] shows bit 0. Bits therefore leave the chain in the order they entered, CH_BITS shifts later.
- R4: On a clock edge with latch_i=1, the whole register of each channel is copied into its latch. Without latch_i the latch and the output codes do not change, whatever shifting takes place.
- R5: When shift_i and latch_i are high on the same edge, the latch receives the register contents as they stood before that shift.
- R6: Output k of channel c (c=0 is channel 1, k=0 is the leftmost output) drives lvl_o[(c*CH_BITS+k)*2 +: 2]. In segment mode a set latch bit gives code 0 when alt_i=0 and 3 when alt_i=1. A clear latch bit gives 2 when alt_i=0 and 1 when alt_i=1.
- R7: With bp_mode_i=1, channel 2 uses the back-plate mapping: a set bit gives 3 when alt_i=0 and 0 when alt_i=1, and a clear bit gives 1 when alt_i=0 and 2 when alt_i=1. Channel 1 ignores bp_mode_i.
- R8: Output codes follow alt_i and bp_mode_i within the same cycle, with no clock edge needed. A set latch bit always yields an extreme code (0 or 3), and a clear latch bit always yields an intermediate code (1 or 2).
- R9: The two channels shift on the common strobe but carry independent data and independent directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | Shift strobe, one clock wide per bit |
| latch_i | input | 1 | Latch strobe, copies registers to latches |
| dir_i | input | 2 | Per-channel direction, 1 moves data toward higher index |
| left_in_i | input | 2 | Serial data into the left end, per channel |
| right_in_i | input | 2 | Serial data into the right end, per channel |
| left_o | output | 2 | Serial data out of the left end, per channel |
| left_oe_o | output | 2 | Left end acts as output, per channel |
| right_o | output | 2 | Serial data out of the right end, per channel |
| right_oe_o | output | 2 | Right end acts as output, per channel |
| bp_mode_i | input | 1 | Channel 2 back-plate mode |
| alt_i | input | 1 | Drive polarity alternation (M) |
| lvl_o | output | 80 | 2-bit level code per output, 40 outputs |

## Verification
On every cycle the assertions check the shift entry at the correct end for each direction, that registers hold without a strobe and latches hold without a latch strobe, that the latch copies the pre-edge register, that the end port roles and departing bits are correct, and that every output's code is extreme exactly when its latch bit is set. The exact polarity codes for each mode and alt_i value, the cascade order over a full register of shifts, the one-hot scan walk in back-plate mode and the reset codes can only be shown by the bench's scenarios. These scenarios sweep every direction pairing with distinct patterns and compare all 40 outputs under all four mode and polarity combinations.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  typedef enum logic [1:0] {
    LVL_0 = 2'd0,
    LVL_1 = 2'd1,
    LVL_2 = 2'd2,
    LVL_3 = 2'd3
  } lvl_code_e;

  // segment: selected -> extreme, unselected -> intermediate, polarity by alt
  function automatic lvl_code_e seg_code(input logic sel, input logic alt);
    if (sel) return alt ? LVL_3 : LVL_0;
    else     return alt ? LVL_1 : LVL_2;
  endfunction

  // back plate: inverse polarity of segment so selected pairs see full swing
  function automatic lvl_code_e bp_code(input logic sel, input logic alt);
    if (sel) return alt ? LVL_0 : LVL_3;
    else     return alt ? LVL_2 : LVL_1;
  endfunction

endpackage

// File: rtl/lcd_shift_chain.sv
module lcd_shift_chain #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         dir_i,
  input  logic         left_in_i,
  input  logic         right_in_i,
  output logic         left_o,
  output logic         left_oe_o,
  output logic         right_o,
  output logic         right_oe_o,
  output logic [N-1:0] data_o
);

  logic [N-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
    end else if (shift_i) begin
      if (dir_i) sreg_q <= {sreg_q[N-2:0], left_in_i};
      else       sreg_q <= {right_in_i, sreg_q[N-1:1]};
    end
  end

  assign right_oe_o = dir_i;
  assign left_oe_o  = ~dir_i;
  assign right_o    = dir_i  & sreg_q[N-1];
  assign left_o     = ~dir_i & sreg_q[0];
  assign data_o     = sreg_q;

endmodule

// File: rtl/lcd_latch_bank.sv
module lcd_latch_bank #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (latch_i) q_o <= d_i;
  end

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_drv_pkg::*;
#(
  parameter int unsigned N = 20
) (
  input  logic [N-1:0]   lat_i,
  input  logic           alt_i,
  input  logic           bp_i,
  output logic [2*N-1:0] lvl_o
);

  for (genvar k = 0; k < N; k++) begin : g_out
    lvl_code_e code;
    always_comb begin
      if (bp_i) code = bp_code(lat_i[k], alt_i);
      else      code = seg_code(lat_i[k], alt_i);
    end
    assign lvl_o[2*k +: 2] = code;
  end

endmodule

// File: rtl/lcd_dual_drv.sv
module lcd_dual_drv #(
  parameter int unsigned CH_BITS = 20
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   shift_i,
  input  logic                   latch_i,
  input  logic [1:0]             dir_i,
  input  logic [1:0]             left_in_i,
  input  logic [1:0]             right_in_i,
  output logic [1:0]             left_o,
  output logic [1:0]             left_oe_o,
  output logic [1:0]             right_o,
  output logic [1:0]             right_oe_o,
  input  logic                   bp_mode_i,
  input  logic                   alt_i,
  output logic [4*CH_BITS-1:0]   lvl_o
);

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned ALL_W  = NUM_CH * CH_BITS;

  logic [ALL_W-1:0] sreg_all;
  logic [ALL_W-1:0] lat_all;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // only the last channel can become a back-plate driver
    logic bp_sel;
    assign bp_sel = (c == NUM_CH - 1) ? bp_mode_i : 1'b0;

    lcd_shift_chain #(.N(CH_BITS)) u_chain (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .shift_i    (shift_i),
      .dir_i      (dir_i[c]),
      .left_in_i  (left_in_i[c]),
      .right_in_i (right_in_i[c]),
      .left_o     (left_o[c]),
      .left_oe_o  (left_oe_o[c]),
      .right_o    (right_o[c]),
      .right_oe_o (right_oe_o[c]),
      .data_o     (sreg_all[c*CH_BITS +: CH_BITS])
    );

    lcd_latch_bank #(.N(CH_BITS)) u_latch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .latch_i (latch_i),
      .d_i     (sreg_all[c*CH_BITS +: CH_BITS]),
      .q_o     (lat_all[c*CH_BITS +: CH_BITS])
    );

    lcd_level_map #(.N(CH_BITS)) u_map (
      .lat_i (lat_all[c*CH_BITS +: CH_BITS]),
      .alt_i (alt_i),
      .bp_i  (bp_sel),
      .lvl_o (lvl_o[c*2*CH_BITS +: 2*CH_BITS])
    );
  end

endmodule

// File: rtl/lcd_dual_drv_chk.sv
module lcd_dual_drv_chk #(
  parameter int unsigned CH_BITS = 20
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 shift_i,
  input logic                 latch_i,
  input logic [1:0]           dir_i,
  input logic [1:0]           left_in_i,
  input logic [1:0]           right_in_i,
  input logic [1:0]           left_o,
  input logic [1:0]           left_oe_o,
  input logic [1:0]           right_o,
  input logic [1:0]           right_oe_o,
  input logic [4*CH_BITS-1:0] lvl_o,
  input logic [2*CH_BITS-1:0] sreg_i,
  input logic [2*CH_BITS-1:0] lat_i
);

  assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(lat_i));

  assert_latch_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> lat_i == $past(sreg_i));

  assert_shift_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sreg_i));

  for (genvar c = 0; c < 2; c++) begin : g_c
    assert_enter_left_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i && dir_i[c] |=> sreg_i[c*CH_BITS] == $past(left_in_i[c]));

    assert_enter_right_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i && !dir_i[c] |=> sreg_i[c*CH_BITS+CH_BITS-1] == $past(right_in_i[c]));

    assert_pin_role_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({left_oe_o[c], right_oe_o[c]}) == 1 && right_oe_o[c] == dir_i[c]);

    assert_tail_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_i[c] |-> right_o[c] == sreg_i[c*CH_BITS+CH_BITS-1] && !left_o[c]);

    assert_head_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dir_i[c] |-> left_o[c] == sreg_i[c*CH_BITS] && !right_o[c]);
  end

  for (genvar j = 0; j < 2*CH_BITS; j++) begin : g_o
    assert_extreme_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lat_i[j] == (lvl_o[2*j +: 2] == 2'd0 || lvl_o[2*j +: 2] == 2'd3));
  end

endmodule

bind lcd_dual_drv lcd_dual_drv_chk #(.CH_BITS(CH_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shift_i    (shift_i),
  .latch_i    (latch_i),
  .dir_i      (dir_i),
  .left_in_i  (left_in_i),
  .right_in_i (right_in_i),
  .left_o     (left_o),
  .left_oe_o  (left_oe_o),
  .right_o    (right_o),
  .right_oe_o (right_oe_o),
  .lvl_o      (lvl_o),
  .sreg_i     (sreg_all),
  .lat_i      (lat_all)
);

// File: tb/lcd_dual_drv_tb.sv
module lcd_dual_drv_tb;

  localparam int N       = 20;
  localparam int CLK_PER = 10;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           shift = 0, latch = 0, bp = 0, alt = 0;
  logic [1:0]     dir = 2'b11, lin = 0, rin = 0;
  logic [1:0]     lo, loe, ro, roe;
  logic [4*N-1:0] lvl;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_sreg [2];
  logic [N-1:0] m_lat  [2];

  always #(CLK_PER/2) clk = ~clk;

  lcd_dual_drv #(.CH_BITS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .latch_i(latch),
    .dir_i(dir), .left_in_i(lin), .right_in_i(rin),
    .left_o(lo), .left_oe_o(loe), .right_o(ro), .right_oe_o(roe),
    .bp_mode_i(bp), .alt_i(alt), .lvl_o(lvl)
  );

  function automatic logic [1:0] exp_code(bit is_bp, bit sel, bit m);
    if (!is_bp) return sel ? (m ? 2'd3 : 2'd0) : (m ? 2'd1 : 2'd2);
    return sel ? (m ? 2'd0 : 2'd3) : (m ? 2'd2 : 2'd1);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // compare all 40 codes against the model latch for the current bp/alt
  task automatic chk_outputs(string req);
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < N; k++)
        chk(req, lvl[(c*N+k)*2 +: 2],
            exp_code(c == 1 && bp, m_lat[c][k], alt));
  endtask

  // one strobe cycle, called at a negedge, returns at the next negedge
  task automatic step(bit s, bit l, logic [1:0] li, logic [1:0] ri);
    shift = s; latch = l; lin = li; rin = ri;
    @(negedge clk);
    if (l) begin m_lat[0] = m_sreg[0]; m_lat[1] = m_sreg[1]; end
    if (s)
      for (int c = 0; c < 2; c++)
        m_sreg[c] = dir[c] ? {m_sreg[c][N-2:0], li[c]} : {ri[c], m_sreg[c][N-1:1]};
    shift = 0; latch = 0;
  endtask

  task automatic chk_pins(string req);
    for (int c = 0; c < 2; c++) begin
      chk(req, {loe[c], roe[c]}, dir[c] ? 2'b01 : 2'b10);
      chk(req, {lo[c], ro[c]}, dir[c] ? {1'b0, m_sreg[c][N-1]} : {m_sreg[c][0], 1'b0});
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_sreg[0] = '0; m_sreg[1] = '0; m_lat[0] = '0; m_lat[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, both polarities
    alt = 0; #1 chk_outputs("R1 reset alt0");
    alt = 1; #1 chk_outputs("R1 reset alt1");
    alt = 0;

    // R2 R3 R6 R7 R8 R9: sweep every direction pairing with distinct patterns
    for (int t = 0; t < 8; t++) begin
      logic [N-1:0] p0, p1;
      logic [N-1:0] held0, held1;
      p0 = N'((t * 32'h9E37 + 32'h1234) ^ (t << 7));
      p1 = N'((t * 32'h5A5B + 32'h0F0F) ^ (t << 3));
      dir = t[1:0];
      @(negedge clk);
      chk_pins("R3 pin roles");
      held0 = m_lat[0]; held1 = m_lat[1];
      for (int b = 0; b < N; b++)
        step(1, 0, {p1[b], p0[b]}, {p1[b], p0[b]});
      // R4: nothing latched yet
      chk_outputs("R4 hold before latch");
      chk("R4 model held", {m_lat[1], m_lat[0]}, {held1, held0});
      step(0, 1, 2'b00, 2'b00);
      for (int m = 0; m < 4; m++) begin
        bp = m[1]; alt = m[0];
        #1;
        chk_outputs(bp ? "R7 back-plate codes" : "R6 segment codes");
      end
      bp = 0; alt = 0;
      // R3 cascade: first bit in is first bit out, in order
      for (int b = 0; b < N; b++) begin
        chk("R3 cascade ch1", dir[0] ? ro[0] : lo[0], p0[dir[0] ? b : b]);
        chk("R3 cascade ch2", dir[1] ? ro[1] : lo[1], p1[b]);
        chk_pins("R3 tail bit");
        step(1, 0, 2'b00, 2'b00);
      end
      chk_outputs("R4 latch unaffected by shifting");
    end

    // R5: latch and shift on the same edge
    dir = 2'b11;
    @(negedge clk);
    for (int b = 0; b < N; b++) step(1, 0, 2'b11, 2'b00);
    step(1, 1, 2'b00, 2'b00);
    chk("R5 latch ch1 pre-shift", lvl[(N-1)*2 +: 2], 2'd0);
    chk("R5 latch ch1 bit0 pre-shift", lvl[1:0], 2'd0);
    chk_outputs("R5 same-edge latch");

    // R7: one-hot scan walk on channel 2, channel 1 stays segment
    bp = 1; alt = 0; dir = 2'b11;
    @(negedge clk);
    for (int b = 0; b < N; b++) step(1, 0, 2'b00, 2'b00);
    step(1, 0, 2'b10, 2'b00);
    for (int line = 0; line < N; line++) begin
      step(0, 1, 2'b00, 2'b00);
      for (int k = 0; k < N; k++)
        chk("R7 scan row", lvl[(N+k)*2 +: 2], (k == line) ? 2'd3 : 2'd1);
      chk("R7 ch1 ignores mode", lvl[1:0], exp_code(0, m_lat[0][0], alt));
      step(1, 0, 2'b00, 2'b00);
    end

    // R8: alt and mode take effect without a clock edge
    @(posedge clk); #1;
    alt = 1; #1 chk_outputs("R8 alt no clock");
    bp = 0;  #1 chk_outputs("R8 mode no clock");

    // R1: reset mid-operation clears everything
    @(negedge clk);
    rst_n = 0; #1;
    m_sreg[0] = '0; m_sreg[1] = '0; m_lat[0] = '0; m_lat[1] = '0;
    alt = 0; #1 chk_outputs("R1 async clear");
    chk_pins("R1 registers cleared");
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule